// File: doc/BRIEF.md
# Miscellaneous Status Register with Interrupt

This block holds one 64-bit control/status word behind a single-cycle register-access port. Software can load the word outright, set bits into it by OR, or (depending on the generation chosen by a parameter) either mask it by AND or wipe it to zero. Only the sixteen most significant bits are kept; the rest always read as zero. The top bit of the stored word is driven out as a level interrupt toward an interrupt controller.

The word offset of an access is the byte address with its three low bits dropped; every access moves a full 64-bit word. Three consecutive offsets are decoded. Their base and the meaning of the third one depend on the generation parameter. Reads return the word only at the direct offset, with a registered read-data path. Any access to an offset that is not decoded raises a one-cycle diagnostic flag.

Top module: `misc_stat_irq`

## Requirements
- R1: After reset, the stored word is zero, the interrupt output is low, and the read-valid and unimplemented-access flag outputs are low.
- R2: A write to the direct offset (0x4020 in generation A, 0x6080 in generation B) stores the write data ANDed with 0xFFFF000000000000. A later read of the direct offset returns the stored word on read data, with read-valid high, in the cycle after the read is accepted.
- R3: A write to the OR offset (0x4022 in generation A, 0x6082 in generation B) stores the bitwise OR of the current word and the write data, masked as in R2.
- R4: In generation A, a write to offset 0x4021 stores the bitwise AND of the current word and the write data, masked as in R2.
- R5: In generation B, a write to offset 0x6081 sets the word to zero, whatever the write data.
- R6: The interrupt output equals bit 63 of the stored word. It updates at the clock edge that accepts the write, on every decoded write, including writes that leave the word unchanged.
- R7: A read of a decoded offset other than the direct one returns zero with read-valid high in the next cycle.
- R8: An access to an undecoded offset leaves the word unchanged. It returns zero on a read and raises the unimplemented-access flag for exactly the cycle after the access.
- R9: The word offset is byte address bits [ADDR_W-1:3]. Byte address bits [2:0] do not affect decode.
- R10: In generation B, the generation A offsets (0x4020 to 0x4022) are undecoded.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Level interrupt, equal to the stored top bit |
| unimpl_o | output | 1 | One-cycle pulse after an undecoded access |

## Verification
The word is driven through a chain of loads, OR-sets and AND-masks whose data has ones in the discarded low 48 bits. This shows whether masking is applied after every operation and not only on loads. OR data that sets bit 63, followed by AND data that clears it, separates a correctly tracked interrupt from one that lags or latches. A rewrite of an unchanged value checks that the interrupt is re-evaluated. A second instance in generation B shows that the clear alias ignores all-ones data and that the generation A offsets fall through to the unimplemented flag. Reads at alias and undecoded offsets, and a nonzero byte-offset write, check that read-back and decode depend only on the word offset.

// File: rtl/miscreg_pkg.sv
package miscreg_pkg;

    localparam int GEN_A = 0;
    localparam int GEN_B = 1;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_AND,
        OP_CLEAR,
        OP_OR
    } wr_op_e;

    typedef struct packed {
        logic   hit;     // offset is one of the three decoded aliases
        logic   direct;  // offset is the direct read/write alias
        wr_op_e op;      // write operation to apply this cycle
    } dec_t;

    function automatic int unsigned base_offset(input int gen);
        return (gen == GEN_B) ? 32'h6080 : 32'h4020;
    endfunction

endpackage

// File: rtl/misc_decode.sv
module misc_decode
    import miscreg_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int GEN    = GEN_A
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int OFF_W = ADDR_W - 3;
    localparam logic [OFF_W-1:0] BASE = OFF_W'(base_offset(GEN));
    localparam logic [OFF_W-1:0] OFF_MID = BASE + OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_OR  = BASE + OFF_W'(2);

    logic [OFF_W-1:0] offset;
    logic [2:0]       unused_byte_lane;
    wr_op_e           mid_op;

    assign offset           = addr[ADDR_W-1:3];
    assign unused_byte_lane = addr[2:0];

    generate
        if (GEN == GEN_B) begin : g_clear
            assign mid_op = OP_CLEAR;
        end else begin : g_and
            assign mid_op = OP_AND;
        end
    endgenerate

    always_comb begin
        dec.hit    = 1'b0;
        dec.direct = 1'b0;
        dec.op     = OP_IDLE;
        if (offset == BASE) begin
            dec.hit    = 1'b1;
            dec.direct = 1'b1;
            if (valid && we) dec.op = OP_LOAD;
        end else if (offset == OFF_MID) begin
            dec.hit = 1'b1;
            if (valid && we) dec.op = mid_op;
        end else if (offset == OFF_OR) begin
            dec.hit = 1'b1;
            if (valid && we) dec.op = OP_OR;
        end
    end
endmodule

// File: rtl/misc_store.sv
module misc_store
    import miscreg_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int KEEP_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_op_e            op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_q,
    output logic              irq_q
);
    localparam int DROP_BITS = DATA_W - KEEP_BITS;
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{KEEP_BITS{1'b1}}, {DROP_BITS{1'b0}}};

    logic [DATA_W-1:0] raw_next;
    logic [DATA_W-1:0] value_next;

    always_comb begin
        unique case (op)
            OP_LOAD:  raw_next = wdata;
            OP_AND:   raw_next = value_q & wdata;
            OP_OR:    raw_next = value_q | wdata;
            OP_CLEAR: raw_next = '0;
            default:  raw_next = value_q;
        endcase
        value_next = raw_next & KEEP_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            irq_q   <= 1'b0;
        end else if (op != OP_IDLE) begin
            value_q <= value_next;
            irq_q   <= value_next[DATA_W-1];
        end
    end

    // R3: an OR write never clears a bit that was set
    assert_or_keeps_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_OR) |=> ((value_q & $past(value_q)) == $past(value_q)));

    // R5: the clear alias leaves zero regardless of data
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> (value_q == '0));

    // R2: dropped bits stay zero after any update
    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (op != OP_IDLE) |=> (value_q[DROP_BITS-1:0] == '0));
endmodule

// File: rtl/misc_readback.sv
module misc_readback
    import miscreg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              we,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              unimpl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            unimpl <= 1'b0;
        end else begin
            rvalid <= valid && !we;
            unimpl <= valid && !dec.hit;
            if (valid && !we)
                rdata <= dec.direct ? value : '0;
        end
    end

    // R7: every accepted read is answered one cycle later
    assert_read_answered_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !we) |=> rvalid);

    // R7: reads away from the direct alias return zero
    assert_alias_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !we && !dec.direct) |=> (rdata == '0));
endmodule

// File: rtl/misc_stat_irq.sv
module misc_stat_irq
    import miscreg_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int KEEP_BITS = 16,
    parameter int ADDR_W    = 20,
    parameter int GEN       = GEN_A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_o,
    output logic              unimpl_o
);
    dec_t              dec;
    logic [DATA_W-1:0] value_q;

    misc_decode #(.ADDR_W(ADDR_W), .GEN(GEN)) u_decode (
        .valid (bus_valid),
        .we    (bus_we),
        .addr  (bus_addr),
        .dec   (dec)
    );

    misc_store #(.DATA_W(DATA_W), .KEEP_BITS(KEEP_BITS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .op      (dec.op),
        .wdata   (bus_wdata),
        .value_q (value_q),
        .irq_q   (irq_o)
    );

    misc_readback #(.DATA_W(DATA_W)) u_readback (
        .clk    (clk),
        .rst    (rst),
        .valid  (bus_valid),
        .we     (bus_we),
        .dec    (dec),
        .value  (value_q),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid),
        .unimpl (unimpl_o)
    );

    // R1: leaving reset, the word and interrupt are clear
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (value_q == '0 && !irq_o && !bus_rvalid && !unimpl_o));

    // R6: interrupt level follows the stored top bit
    assert_irq_tracks_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o == value_q[DATA_W-1]);

    // R8: undecoded access leaves the word alone and flags it
    assert_undecoded_no_change_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !dec.hit) |=> ($stable(value_q) && unimpl_o));
endmodule

// File: tb/misc_stat_irq_test.sv
`timescale 1ns/1ps
module misc_stat_irq_test;
    import miscreg_pkg::*;

    typedef struct packed {
        logic [15:0] off;
        logic [2:0]  lo;
        logic [63:0] wd;
        logic [63:0] exp;
        logic        irq;
        logic        unimp;
    } vec_t;

    // generation A write sequence; each entry is followed by a direct read
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'h4020, 3'd0, 64'h1234_5678_9ABC_DEF0, 64'h1234_0000_0000_0000, 1'b0, 1'b0}, // R2
        '{16'h4022, 3'd0, 64'h8001_FFFF_FFFF_FFFF, 64'h9235_0000_0000_0000, 1'b1, 1'b0}, // R3 R6
        '{16'h4021, 3'd0, 64'h0FF0_FFFF_0000_0000, 64'h0230_0000_0000_0000, 1'b0, 1'b0}, // R4 R6
        '{16'h4020, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_0000, 1'b1, 1'b0}, // R9
        '{16'h4023, 3'd0, 64'h0000_0000_0000_0000, 64'hFFFF_0000_0000_0000, 1'b1, 1'b1}, // R8
        '{16'h4021, 3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_0000_0000_0000, 1'b0, 1'b0}, // R4 R6
        '{16'h4020, 3'd0, 64'h7FFF_0000_0000_0000, 64'h7FFF_0000_0000_0000, 1'b0, 1'b0}  // R6
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        va = 0, wea = 0, vb = 0, web = 0;
    logic [19:0] aa = '0, ab = '0;
    logic [63:0] wda = '0, wdb = '0;
    logic [63:0] rda, rdb;
    logic        rva, rvb, irqa, irqb, una, unb;

    misc_stat_irq #(.GEN(GEN_A)) uut (
        .clk(clk), .rst(rst), .bus_valid(va), .bus_we(wea), .bus_addr(aa),
        .bus_wdata(wda), .bus_rdata(rda), .bus_rvalid(rva), .irq_o(irqa),
        .unimpl_o(una));

    misc_stat_irq #(.GEN(GEN_B)) uut_b (
        .clk(clk), .rst(rst), .bus_valid(vb), .bus_we(web), .bus_addr(ab),
        .bus_wdata(wdb), .bus_rdata(rdb), .bus_rvalid(rvb), .irq_o(irqb),
        .unimpl_o(unb));

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] c_rd;
    logic        c_rv, c_irq, c_un;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit b, input bit we, input logic [15:0] off,
                       input logic [2:0] lo, input logic [63:0] wd);
        @(negedge clk);
        if (!b) begin va = 1; wea = we; aa = {1'b0, off, lo}; wda = wd; end
        else    begin vb = 1; web = we; ab = {1'b0, off, lo}; wdb = wd; end
        @(posedge clk);
        #1;
        c_rd  = b ? rdb  : rda;
        c_rv  = b ? rvb  : rva;
        c_irq = b ? irqb : irqa;
        c_un  = b ? unb  : una;
        @(negedge clk);
        va = 0; vb = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset irq", {63'd0, irqa}, 64'd0);
        chk("R1 reset rvalid/unimpl", {62'd0, rva, una}, 64'd0);
        @(negedge clk); rst = 0;
        acc(0, 0, 16'h4020, 3'd0, '0);
        chk("R1 reset read", c_rd, 64'd0);

        for (int i = 0; i < NV; i++) begin
            acc(0, 1, VECS[i].off, VECS[i].lo, VECS[i].wd);
            chk($sformatf("R6 irq after write %0d", i), {63'd0, c_irq}, {63'd0, VECS[i].irq});
            chk($sformatf("R8 unimpl after write %0d", i), {63'd0, c_un}, {63'd0, VECS[i].unimp});
            acc(0, 0, 16'h4020, 3'd0, '0);
            chk($sformatf("R2/R3/R4/R9 readback %0d", i), c_rd, VECS[i].exp);
            chk($sformatf("R2 rvalid %0d", i), {63'd0, c_rv}, 64'd1);
        end

        // R7: alias reads return zero
        acc(0, 0, 16'h4022, 3'd0, '0);
        chk("R7 OR alias read", c_rd, 64'd0);
        chk("R7 rvalid", {63'd0, c_rv}, 64'd1);
        acc(0, 0, 16'h4021, 3'd0, '0);
        chk("R7 AND alias read", c_rd, 64'd0);
        // R8: undecoded read
        acc(0, 0, 16'h5000, 3'd0, '0);
        chk("R8 undecoded read data", c_rd, 64'd0);
        chk("R8 undecoded read flag", {63'd0, c_un}, 64'd1);
        @(posedge clk); #1;
        chk("R8 flag is one cycle", {63'd0, una}, 64'd0);

        // generation B
        acc(1, 1, 16'h6080, 3'd0, 64'hC000_1234_5678_9ABC);
        chk("R6 gen B irq", {63'd0, c_irq}, 64'd1);
        acc(1, 0, 16'h6080, 3'd0, '0);
        chk("R2 gen B direct", c_rd, 64'hC000_0000_0000_0000);
        acc(1, 1, 16'h6082, 3'd0, 64'h0001_0000_0000_FFFF);
        acc(1, 0, 16'h6080, 3'd0, '0);
        chk("R3 gen B OR", c_rd, 64'hC001_0000_0000_0000);
        acc(1, 1, 16'h4020, 3'd0, 64'h0);
        chk("R10 gen A offset flagged in B", {63'd0, c_un}, 64'd1);
        acc(1, 0, 16'h6080, 3'd0, '0);
        chk("R10 gen A offset no effect in B", c_rd, 64'hC001_0000_0000_0000);
        acc(1, 1, 16'h6081, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 clear drops irq", {63'd0, c_irq}, 64'd0);
        acc(1, 0, 16'h6080, 3'd0, '0);
        chk("R5 clear ignores data", c_rd, 64'd0);

        // R1: reset in the middle of operation
        acc(0, 1, 16'h4020, 3'd0, 64'h8000_0000_0000_0000);
        chk("R6 irq set before reset", {63'd0, c_irq}, 64'd1);
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        chk("R1 reset drops irq", {63'd0, irqa}, 64'd0);
        @(negedge clk); rst = 0;
        acc(0, 0, 16'h4020, 3'd0, '0);
        chk("R1 word cleared by reset", c_rd, 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule